// File: doc/BRIEF.md
# Static Memory Bank Timing Controller

This block runs one chip-select bank of asynchronous SRAM or flash from a synchronous host port. The host raises a request with a byte address, write data, byte enables and a direction flag. The controller then drives chip select, output enable, write enable, byte-lane strobes, a word address and write data toward the memory. Every phase of the access is timed in bus clock cycles from static configuration inputs. Each phase has its own offset, so a field value of n gives n, n+1 or n+2 cycles depending on the phase.

Reads can run in page mode, where one request returns four beats from an aligned group of four words. The first beat uses the normal read wait and the following beats use a shorter wait. An active-low wait input can stretch any access. A timeout counted in units of 16 cycles aborts an access that waits too long. Write protection, selectable chip-select polarity and two byte-strobe conventions are provided. The configuration inputs must stay constant while `hbusy` is high.

Top module: `sram_timing_ctl`

## Requirements
- R1: After reset, chip select is at its inactive level, `mem_oe_n` and `mem_we_n` are 1, and `hbusy` and `hack` are 0.
- R2: When `cfg_cs_high` is 1, chip select is driven 1 during an access and 0 otherwise. When it is 0, chip select is driven 0 during an access and 1 otherwise. The access begins in the cycle after the request is taken.
- R3: In a read, counting the first chip-select cycle as cycle 0, `mem_oe_n` goes low in cycle `cfg_oe_lag` and stays low until the read ends. Output enable is never active during a write, and never active while write enable is active.
- R4: A write keeps chip select active for `cfg_wr_wait`+2 cycles. `mem_we_n` is low from cycle `cfg_we_lag`+1 up to and including cycle `cfg_wr_wait`, and stays high if that range is empty.
- R5: A read without page mode keeps chip select active for `cfg_rd_wait`+1 cycles. `mem_din` is captured on the last of those cycles. `hack` pulses for one cycle in the next cycle, with that word on `hrdata` and `herr` at 0.
- R6: With `cfg_page` set, a read returns four beats. The word address low two bits start at the requested value and increment modulo 4. The first beat lasts `cfg_rd_wait`+1 cycles and each later beat lasts `cfg_pg_wait`+1 cycles. Chip select and output enable stay active across the beats. One `hack` per beat appears in the first cycle of the following beat, or of the turnaround.
- R7: After an access, chip select is inactive for `cfg_turn`+1 turnaround cycles with `hbusy` still 1. `hbusy` is 1 from the cycle after a request is taken until the turnaround ends. A request is taken only in a cycle where `hbusy` is 0.
- R8: With `cfg_lane_low` at 0, the byte strobes `mem_lane` carry the selected lanes active high during reads and active low during writes, and are 0 outside an access. With `cfg_lane_low` at 1, they are active low in both directions and are all ones outside an access.
- R9: `cfg_width` gives the memory width: 0 for 8 bits, 1 for 16 bits, 2 for 32 bits. `mem_addr` is the host byte address shifted right by `cfg_width`. The selected lane bits are `hbe[haddr[1:0]]` on lane 0 for width 0, `hbe[3:2]` or `hbe[1:0]` on lanes 1:0 chosen by `haddr[1]` for width 1, and all of `hbe` for width 2.
- R10: A request taken while `cfg_width` is 3 never activates chip select. It is acknowledged in the next cycle with `herr` at 1 and then runs a normal turnaround.
- R11: With `cfg_xwait` at 1, every access cycle in which `mem_wait_n` is 0 freezes the phase timing, so the access lasts one cycle longer. This includes the last cycle of a beat. With `cfg_xwait` at 0, `mem_wait_n` has no effect.
- R12: Within one beat, the 16×(`cfg_xwait_lim`+1)th cycle with `mem_wait_n` at 0 ends the access at once. The access is acknowledged in the next cycle with `herr` at 1, any remaining page beats are dropped, and the turnaround follows.
- R13: While `cfg_wprot` is 1, a write runs its full timed cycle with `mem_we_n` held high and `mem_dout_en` low. It is acknowledged with `herr` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_lag | input | 4 | Write-enable delay field (active from cycle n+1) |
| cfg_oe_lag | input | 4 | Output-enable delay field (active from cycle n) |
| cfg_rd_wait | input | 5 | First or only read beat length minus one |
| cfg_pg_wait | input | 5 | Later page beat length minus one |
| cfg_wr_wait | input | 5 | Write length minus two |
| cfg_turn | input | 4 | Turnaround length minus one |
| cfg_cs_high | input | 1 | Chip select active level |
| cfg_lane_low | input | 1 | Byte strobes active low in both directions |
| cfg_width | input | 2 | Memory width code, 3 reserved |
| cfg_page | input | 1 | Four-beat page-mode reads |
| cfg_xwait | input | 1 | Honour the wait input |
| cfg_xwait_lim | input | 10 | Wait timeout in units of 16 cycles, minus one |
| cfg_wprot | input | 1 | Write protect |
| hreq | input | 1 | Host request, taken when not busy |
| hwrite | input | 1 | 1 for write, 0 for read |
| haddr | input | AW | Host byte address |
| hwdata | input | 32 | Write data, already placed on memory lanes |
| hbe | input | 4 | Byte enables |
| hack | output | 1 | One-cycle completion pulse per beat |
| herr | output | 1 | Error qualifier of `hack` |
| hrdata | output | 32 | Read data of the last completed read beat |
| hbusy | output | 1 | Access or turnaround in progress |
| mem_cs | output | 1 | Chip select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane | output | 4 | Byte-lane strobes |
| mem_addr | output | AW | Memory word address |
| mem_dout | output | 32 | Write data to memory |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | 32 | Read data from memory |
| mem_wait_n | input | 1 | External wait, active low |

## Verification
The wait input can go low in the same cycle in which a beat would reach its last count. In that case the stall must win and the beat must be one cycle longer; the bench tests this by pulling the wait low in exactly the final cycles of a read and comparing chip select, output enable and the acknowledge cycle by cycle. In page mode the acknowledge of one beat falls in the same cycle as the start of the next beat, with a new address. The bench checks both in that cycle, and checks the captured word against the address of the beat that just ended.

// File: rtl/sram_timing_ctl.sv
module sram_timing_ctl #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    cfg_we_lag,
  input  logic [3:0]    cfg_oe_lag,
  input  logic [4:0]    cfg_rd_wait,
  input  logic [4:0]    cfg_pg_wait,
  input  logic [4:0]    cfg_wr_wait,
  input  logic [3:0]    cfg_turn,
  input  logic          cfg_cs_high,
  input  logic          cfg_lane_low,
  input  logic [1:0]    cfg_width,
  input  logic          cfg_page,
  input  logic          cfg_xwait,
  input  logic [9:0]    cfg_xwait_lim,
  input  logic          cfg_wprot,
  input  logic          hreq,
  input  logic          hwrite,
  input  logic [AW-1:0] haddr,
  input  logic [31:0]   hwdata,
  input  logic [3:0]    hbe,
  output logic          hack,
  output logic          herr,
  output logic [31:0]   hrdata,
  output logic          hbusy,
  output logic          mem_cs,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [3:0]    mem_lane,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_dout,
  output logic          mem_dout_en,
  input  logic [31:0]   mem_din,
  input  logic          mem_wait_n
);

  localparam int CW = 6;
  localparam int TW = 14;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_TURN} st_t;

  st_t           st;
  logic          wr_q, first;
  logic [AW-1:0] word_q;
  logic [31:0]   wdata_q;
  logic [3:0]    lanes_q, lanes_in;
  logic [CW-1:0] cnt, lim;
  logic [1:0]    beat;
  logic [TW-1:0] tmo;
  logic [3:0]    tt;
  logic          acc, stall, pg, last_beat;

  always_comb begin
    case (cfg_width)
      2'd0:    lanes_in = {3'b000, hbe[haddr[1:0]]};
      2'd1:    lanes_in = {2'b00, haddr[1] ? hbe[3:2] : hbe[1:0]};
      default: lanes_in = hbe;
    endcase
  end

  assign acc       = (st == S_ACC);
  assign stall     = cfg_xwait & ~mem_wait_n;
  assign pg        = cfg_page & ~wr_q;
  assign last_beat = ~pg | (beat == 2'd3);
  assign lim       = wr_q  ? {1'b0, cfg_wr_wait} + CW'(1)
                   : first ? {1'b0, cfg_rd_wait} : {1'b0, cfg_pg_wait};

  assign hbusy       = (st != S_IDLE);
  assign mem_cs      = cfg_cs_high ? acc : ~acc;
  assign mem_oe_n    = ~(acc & ~wr_q & (~first | (cnt >= CW'(cfg_oe_lag))));
  assign mem_we_n    = ~(acc & wr_q & ~cfg_wprot &
                         (cnt >= CW'(cfg_we_lag) + CW'(1)) & (cnt <= CW'(cfg_wr_wait)));
  assign mem_lane    = acc ? ((~wr_q & ~cfg_lane_low) ? lanes_q : ~lanes_q) : {4{cfg_lane_low}};
  assign mem_addr    = {word_q[AW-1:2], word_q[1:0] + beat};
  assign mem_dout    = wdata_q;
  assign mem_dout_en = acc & wr_q & ~cfg_wprot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      wr_q    <= 1'b0;
      first   <= 1'b1;
      word_q  <= '0;
      wdata_q <= '0;
      lanes_q <= '0;
      cnt     <= '0;
      beat    <= '0;
      tmo     <= '0;
      tt      <= '0;
      hack    <= 1'b0;
      herr    <= 1'b0;
      hrdata  <= '0;
    end else begin
      hack <= 1'b0;
      herr <= 1'b0;
      case (st)
        S_IDLE: if (hreq) begin
          wr_q    <= hwrite;
          word_q  <= haddr >> cfg_width;
          wdata_q <= hwdata;
          lanes_q <= lanes_in;
          cnt     <= '0;
          beat    <= '0;
          first   <= 1'b1;
          tmo     <= '0;
          tt      <= '0;
          if (cfg_width == 2'd3) begin
            st   <= S_TURN;
            hack <= 1'b1;
            herr <= 1'b1;
          end else begin
            st <= S_ACC;
          end
        end
        S_ACC: begin
          if (stall) begin
            if (tmo == {cfg_xwait_lim, 4'hF}) begin
              hack <= 1'b1;
              herr <= 1'b1;
              st   <= S_TURN;
              tt   <= '0;
            end else begin
              tmo <= tmo + TW'(1);
            end
          end else if (cnt == lim) begin
            hack <= 1'b1;
            herr <= wr_q & cfg_wprot;
            if (!wr_q) hrdata <= mem_din;
            if (last_beat) begin
              st <= S_TURN;
              tt <= '0;
            end else begin
              beat  <= beat + 2'd1;
              cnt   <= '0;
              first <= 1'b0;
              tmo   <= '0;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_TURN: begin
          if (tt == cfg_turn) st <= S_IDLE;
          else tt <= tt + 4'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_timing_ctl_chk.sv
module sram_timing_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_cs_high,
  input logic [1:0] cfg_width,
  input logic       cfg_xwait,
  input logic       cfg_wprot,
  input logic       hack,
  input logic       herr,
  input logic       hbusy,
  input logic       mem_cs,
  input logic       mem_oe_n,
  input logic       mem_we_n,
  input logic       mem_wait_n
);

  logic cs_on;
  assign cs_on = (mem_cs == cfg_cs_high);

  assert_oe_we_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_protect_no_we_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wprot |-> mem_we_n);

  assert_ack_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hack |-> hbusy);

  assert_idle_cs_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hbusy |-> !cs_on);

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hbusy && cs_on && cfg_xwait && !mem_wait_n) |=> (cs_on || herr));

  assert_reserved_no_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_width == 2'd3) |-> !cs_on);

  assert_err_with_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    herr |-> hack);

endmodule

bind sram_timing_ctl sram_timing_ctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_cs_high(cfg_cs_high), .cfg_width(cfg_width),
  .cfg_xwait(cfg_xwait), .cfg_wprot(cfg_wprot), .hack(hack), .herr(herr),
  .hbusy(hbusy), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_wait_n(mem_wait_n)
);

// File: tb/sram_timing_ctl_tb.sv
module sram_timing_ctl_tb_top;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0] cfg_we_lag = 4'd1, cfg_oe_lag = 4'd1, cfg_turn = 4'd1;
  logic [4:0] cfg_rd_wait = 5'd3, cfg_pg_wait = 5'd1, cfg_wr_wait = 5'd3;
  logic cfg_cs_high = 0, cfg_lane_low = 0, cfg_page = 0, cfg_xwait = 0, cfg_wprot = 0;
  logic [1:0] cfg_width = 2'd2;
  logic [9:0] cfg_xwait_lim = 10'd0;
  logic hreq = 0, hwrite = 0;
  logic [AW-1:0] haddr = '0;
  logic [31:0] hwdata = '0;
  logic [3:0] hbe = 4'hF;
  logic hack, herr, hbusy, mem_cs, mem_oe_n, mem_we_n, mem_dout_en;
  logic [31:0] hrdata, mem_dout, mem_din;
  logic [3:0] mem_lane;
  logic [AW-1:0] mem_addr;
  logic mem_wait_n = 1'b1;

  function automatic logic [31:0] mem_word(logic [AW-1:0] a);
    return 32'hC300_0000 ^ {{(32-AW){1'b0}}, a};
  endfunction
  assign mem_din = mem_word(mem_addr);

  sram_timing_ctl #(.AW(AW)) dut_i (.*);

  typedef struct {
    bit wn; bit cs; bit oe; bit we; logic [3:0] lane;
    bit ack; bit err; bit busy; bit chk_rd; logic [31:0] rd;
  } ent_t;
  ent_t q[$];
  int nchk = 0, nfail = 0;
  string cur_tag = "R1";
  bit finished = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    ent_t e;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else begin
      e = '{wn:1, cs:0, oe:0, we:0, lane:{4{cfg_lane_low}}, ack:0, err:0, busy:0, chk_rd:0, rd:0};
    end
    chk(mem_cs == (cfg_cs_high ? e.cs : !e.cs), "R2", "cs", mem_cs, e.cs);
    chk(mem_oe_n == !e.oe, "R3", "oe_n", mem_oe_n, !e.oe);
    chk(mem_we_n == !e.we, "R4", "we_n", mem_we_n, !e.we);
    chk(mem_lane == e.lane, "R8", "lane", mem_lane, e.lane);
    chk(hbusy == e.busy, "R7", "busy", hbusy, e.busy);
    chk(hack == e.ack, cur_tag, "ack", hack, e.ack);
    chk(herr == e.err, cur_tag, "err", herr, e.err);
    if (e.chk_rd) chk(hrdata == e.rd, cur_tag, "rdata", hrdata, e.rd);
    mem_wait_n = e.wn;
  endtask

  task automatic gen(bit wr, logic [AW-1:0] a, logic [3:0] be, int ws, int wl);
    ent_t e;
    logic [3:0] lanes, lact, lidle;
    logic [AW-1:0] w, ba;
    int nb, L, k, low, i;
    bit pa, pe, pr, abort, done;
    logic [31:0] prd;
    lidle = {4{cfg_lane_low}};
    pa = 0; pe = 0; pr = 0; prd = 0; abort = 0; i = 0;
    if (cfg_width != 2'd3) begin
      case (cfg_width)
        2'd0: lanes = be[a[1:0]] ? 4'b0001 : 4'b0000;
        2'd1: lanes = a[1] ? {2'b00, be[3:2]} : {2'b00, be[1:0]};
        default: lanes = be;
      endcase
      lact = (!wr && !cfg_lane_low) ? lanes : ~lanes;
      w = a >> cfg_width;
      nb = (!wr && cfg_page) ? 4 : 1;
      for (int b = 0; b < nb && !abort; b++) begin
        L = wr ? cfg_wr_wait + 2 : (b == 0 ? cfg_rd_wait + 1 : cfg_pg_wait + 1);
        k = 0; low = 0; done = 0;
        ba = {w[AW-1:2], 2'(w[1:0] + 2'(b))};
        while (!done) begin
          e.wn = !(i >= ws && i < ws + wl);
          e.cs = 1; e.busy = 1; e.lane = lact;
          e.oe = !wr && (b > 0 || k >= cfg_oe_lag);
          e.we = wr && !cfg_wprot && k >= cfg_we_lag + 1 && k <= cfg_wr_wait;
          e.ack = pa; e.err = pe; e.chk_rd = pr; e.rd = prd;
          pa = 0; pe = 0; pr = 0;
          q.push_back(e); i++;
          if (cfg_xwait && !e.wn) begin
            low++;
            if (low == 16 * (cfg_xwait_lim + 1)) begin
              pa = 1; pe = 1; abort = 1; done = 1;
            end
          end else if (k == L - 1) begin
            pa = 1; pe = wr && cfg_wprot; pr = !wr; prd = mem_word(ba); done = 1;
          end else k++;
        end
      end
    end else begin
      pa = 1; pe = 1;
    end
    for (int t = 0; t <= cfg_turn; t++) begin
      e = '{wn:1, cs:0, oe:0, we:0, lane:lidle, ack:pa, err:pe, busy:1, chk_rd:pr, rd:prd};
      pa = 0; pe = 0; pr = 0;
      q.push_back(e);
    end
  endtask

  task automatic drain();
    while (q.size() > 0) cyc();
    cyc();
  endtask

  task automatic access(string tag, bit wr, logic [AW-1:0] a, logic [3:0] be,
                        int ws, int wl, bit hold);
    drain();
    cur_tag = tag;
    hwrite = wr; haddr = a; hbe = be; hwdata = 32'h5A00_0000 | 32'(a); hreq = 1;
    gen(wr, a, be, ws, wl);
    cyc();
    if (!hold) hreq = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_cs == 1'b1 && mem_oe_n && mem_we_n, "R1", "reset pins", {mem_cs, mem_oe_n, mem_we_n}, 3'b111);
    chk(!hbusy && !hack, "R1", "reset busy/ack", {hbusy, hack}, 2'b00);
    rst_n = 1;
    cyc();
    // R5 plain read, R3 output-enable lag
    cfg_oe_lag = 4'd2; cfg_rd_wait = 5'd4;
    access("R5", 0, 20'h00124, 4'hF, -1, 0, 0);
    // R4 write timing
    drain(); cfg_we_lag = 4'd1; cfg_wr_wait = 5'd4;
    access("R4", 1, 20'h00200, 4'hF, -1, 0, 0);
    // R4 empty write-enable window
    drain(); cfg_we_lag = 4'd5; cfg_wr_wait = 5'd2;
    access("R4", 1, 20'h00204, 4'h3, -1, 0, 0);
    // R2 active-high chip select
    drain(); cfg_cs_high = 1; cfg_we_lag = 4'd0;
    access("R2", 0, 20'h00300, 4'hF, -1, 0, 0);
    // R8 strobes active low both ways, 16-bit lanes
    drain(); cfg_lane_low = 1; cfg_width = 2'd1;
    access("R8", 1, 20'h00402, 4'b1100, -1, 0, 0);
    access("R8", 0, 20'h00400, 4'b0010, -1, 0, 0);
    // R9 byte-wide memory
    drain(); cfg_lane_low = 0; cfg_width = 2'd0;
    access("R9", 0, 20'h00503, 4'b1000, -1, 0, 0);
    access("R9", 1, 20'h00501, 4'b0010, -1, 0, 0);
    // R3 output-enable lag beyond read end
    drain(); cfg_width = 2'd2; cfg_oe_lag = 4'd9; cfg_rd_wait = 5'd2;
    access("R3", 0, 20'h00600, 4'hF, -1, 0, 0);
    // R6 page read with wrap from word 2
    drain(); cfg_oe_lag = 4'd1; cfg_rd_wait = 5'd3; cfg_pg_wait = 5'd1; cfg_page = 1;
    access("R6", 0, 20'h00708, 4'hF, -1, 0, 0);
    // R11 stall on final cycles of a beat
    drain(); cfg_page = 0; cfg_rd_wait = 5'd4; cfg_xwait = 1; cfg_xwait_lim = 10'd3;
    access("R11", 0, 20'h00800, 4'hF, 4, 3, 0);
    access("R11", 1, 20'h00804, 4'hF, 1, 2, 0);
    // R11 wait ignored when disabled
    drain(); cfg_xwait = 0;
    access("R11", 0, 20'h00808, 4'hF, 1, 4, 0);
    // R12 timeout abort, also mid page burst
    drain(); cfg_xwait = 1; cfg_xwait_lim = 10'd0;
    access("R12", 0, 20'h00900, 4'hF, 1, 30, 0);
    drain(); cfg_page = 1;
    access("R12", 0, 20'h00910, 4'hF, 6, 20, 0);
    // R13 write protect
    drain(); cfg_page = 0; cfg_xwait = 0; cfg_wprot = 1; cfg_we_lag = 4'd0; cfg_wr_wait = 5'd3;
    access("R13", 1, 20'h00A00, 4'hF, -1, 0, 0);
    chk(mem_dout_en == 1'b0, "R13", "dout_en", mem_dout_en, 0);
    // R10 reserved width
    drain(); cfg_wprot = 0; cfg_width = 2'd3;
    access("R10", 0, 20'h00B00, 4'hF, -1, 0, 0);
    // R7 long turnaround, request held across busy
    drain(); cfg_width = 2'd2; cfg_turn = 4'd5;
    access("R7", 0, 20'h00C00, 4'hF, -1, 0, 1);
    access("R7", 1, 20'h00C04, 4'hF, -1, 0, 0);
    drain();
    summary();
  end
endmodule